// File: doc/BRIEF.md
# Alternating Run-Pattern Detector

This block watches a serial bit stream, one bit per clock, and raises a one-cycle pulse each time it recognises a run of three equal bits that it is currently hunting for. It works in two alternating phases. In the zero phase it needs two separate runs of three zeros. Once both have been seen it moves to the one phase, where a single run of three ones is enough to bring it back to the zero phase. While it is in one phase, runs of the other phase's value have no effect.

The three zeros of a match are used up by that match. The next zero match needs three fresh zeros, so runs cannot overlap. A bit of the opposite value restarts the run count. The output is a Moore output and comes straight from state: it rises in the cycle after the third matching bit.

The whole state fits in four flip-flops: one for the phase, one for the zero-match count and two for the run counter. The run counter's spare code marks the cycle right after a hit. That mark drives the output, and the counter treats it as a run length of zero.

Top module: `alt_run_detector`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is zero phase with the run count and the zero-match count cleared, and `detectOut` is 0 after that edge.
- R2: In the zero phase, three consecutive 0 bits produce `detectOut` = 1 for the cycle after the edge that sampled the third 0.
- R3: Matches do not overlap. After a hit, the run count restarts, so a run of six zeros gives exactly two pulses, on the 3rd and the 6th zero. A run of four or five zeros gives one pulse.
- R4: A bit of the value opposite to the current phase clears the run count. For example, 0,0,1,0,0 gives no pulse in the zero phase.
- R5: After the second zero hit the block is in the one phase, and any number of 0 bits there produce no pulse.
- R6: In the one phase, three consecutive 1 bits produce a pulse in the cycle after the third 1 and return the block to the zero phase. More 1 bits produce no pulse until two new zero hits and a new run of three ones have occurred.
- R7: The one-run count is zero when the one phase is entered. The first pulse in that phase needs three 1 bits that all arrive after the second zero hit.
- R8: `detectOut` is never high for two consecutive cycles, and after any pulse it stays low for at least the next two cycles, even when the matching value continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | 1 | Serial input bit, sampled each rising edge |
| detectOut | output | 1 | One-cycle detection pulse (Moore, registered state) |

## Verification
Directed patterns come first. A run of zeros broken by a one shows that the run count resets. Six zeros in a row separate a correct non-overlapping count from an overlapping one. Zeros sent in the one phase and repeated ones after the 111 hit show that each phase ignores the other phase's value. A reset in the middle of a run shows that partial runs are lost. After these, a long random stream made of runs of random length (one to six bits) tests every phase transition at many run alignments. This stream is compared cycle by cycle against a behavioural reference that tracks the phase, the run length and the zero-match count.

// File: rtl/alt_run_pkg.sv
package alt_run_pkg;

  typedef enum logic {
    PHASE_ZERO = 1'b0,
    PHASE_ONE  = 1'b1
  } phaseT;

  // Strobes from control to the run-count datapath
  typedef struct packed {
    logic runStep;   // current bit continues the run being hunted
    logic runHit;    // current bit completes the run
  } runStrobeT;

endpackage

// File: rtl/alt_run_datapath.sv
module alt_run_datapath
  import alt_run_pkg::*;
#(
  parameter int RUN_LEN = 3
) (
  input  logic      clk,
  input  logic      rst,
  input  runStrobeT strobe,
  output logic      runAtLast,
  output logic      hitMark
);

  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam logic [RUN_W-1:0] MARK = RUN_W'(RUN_LEN);
  localparam logic [RUN_W-1:0] LAST = RUN_W'(RUN_LEN - 1);

  logic [RUN_W-1:0] runCnt;
  logic [RUN_W-1:0] runNext;

  // The mark code stands for "just hit": it behaves as length zero
  always_comb begin
    if (strobe.runHit)
      runNext = MARK;
    else if (strobe.runStep)
      runNext = (runCnt == MARK) ? RUN_W'(1) : runCnt + RUN_W'(1);
    else
      runNext = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)
      runCnt <= '0;
    else
      runCnt <= runNext;
  end

  assign runAtLast = (runCnt == LAST);
  assign hitMark   = (runCnt == MARK);

endmodule

// File: rtl/alt_run_control.sv
module alt_run_control
  import alt_run_pkg::*;
#(
  parameter int ZERO_HITS = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      bitIn,
  input  logic      runAtLast,
  output runStrobeT strobe,
  output phaseT     phase
);

  localparam int HIT_W = (ZERO_HITS > 1) ? $clog2(ZERO_HITS) : 1;
  localparam logic [HIT_W-1:0] HIT_LAST = HIT_W'(ZERO_HITS - 1);

  logic [HIT_W-1:0] hitCnt;
  logic             bitMatch;

  assign bitMatch       = (phase == PHASE_ZERO) ? ~bitIn : bitIn;
  assign strobe.runStep = bitMatch;
  assign strobe.runHit  = bitMatch & runAtLast;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PHASE_ZERO;
      hitCnt <= '0;
    end else if (strobe.runHit) begin
      if (phase == PHASE_ZERO) begin
        if (hitCnt == HIT_LAST) begin
          phase  <= PHASE_ONE;
          hitCnt <= '0;
        end else begin
          hitCnt <= hitCnt + HIT_W'(1);
        end
      end else begin
        phase <= PHASE_ZERO;
      end
    end
  end

endmodule

// File: rtl/alt_run_detector.sv
module alt_run_detector
  import alt_run_pkg::*;
#(
  parameter int RUN_LEN   = 3,
  parameter int ZERO_HITS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic dataIn,
  output logic detectOut
);

  runStrobeT strobe;
  phaseT     phase;
  logic      runAtLast;
  logic      hitMark;
  logic      phaseIsOne;

  alt_run_control #(.ZERO_HITS(ZERO_HITS)) i_control (
    .clk       (clk),
    .rst       (rst),
    .bitIn     (dataIn),
    .runAtLast (runAtLast),
    .strobe    (strobe),
    .phase     (phase)
  );

  alt_run_datapath #(.RUN_LEN(RUN_LEN)) i_datapath (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .runAtLast (runAtLast),
    .hitMark   (hitMark)
  );

  assign phaseIsOne = (phase == PHASE_ONE);
  assign detectOut  = hitMark;

endmodule

// File: rtl/alt_run_checker.sv
module alt_run_checker (
  input logic clk,
  input logic rst,
  input logic dataIn,
  input logic detectOut,
  input logic phaseIsOne
);

  // R1: reset leaves the output low
  a_r1_reset_low: assert property (@(posedge clk) rst |=> !detectOut);

  // R8 / R3: a hit consumes its run, so two quiet cycles follow
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    detectOut |=> !detectOut);
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (rst)
    detectOut |=> ##1 !detectOut);

  // R2: a pulse follows three equal input bits
  a_r2_three_equal: assert property (@(posedge clk) disable iff (rst)
    detectOut |-> ($past(dataIn) == $past(dataIn, 2)) &&
                  ($past(dataIn, 2) == $past(dataIn, 3)));

  // R6: a ones hit leaves the block in the zero phase
  a_r6_back_to_zero: assert property (@(posedge clk) disable iff (rst)
    (detectOut && $past(dataIn)) |-> !phaseIsOne);

  // R5: a zeros hit never happens while in the one phase
  a_r5_zero_ignored: assert property (@(posedge clk) disable iff (rst)
    (phaseIsOne && !dataIn) |=> !detectOut);

endmodule

bind alt_run_detector alt_run_checker i_checker (
  .clk        (clk),
  .rst        (rst),
  .dataIn     (dataIn),
  .detectOut  (detectOut),
  .phaseIsOne (phaseIsOne)
);

// File: tb/test_alt_run_detector.sv
`timescale 1ns/1ps
module test_alt_run_detector;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dataIn = 1'b0;
  logic detectOut;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // behavioural reference state
  int  mPhase = 0;
  int  mRun = 0;
  int  mHits = 0;
  bit  mZ = 0;

  always #2 clk = ~clk;

  alt_run_detector i_alt_run_detector (
    .clk       (clk),
    .rst       (rst),
    .dataIn    (dataIn),
    .detectOut (detectOut)
  );

  function automatic void refReset();
    mPhase = 0; mRun = 0; mHits = 0; mZ = 0;
  endfunction

  function automatic void refStep(bit b);
    bit match;
    match = (mPhase == 0) ? !b : b;
    mZ = 0;
    if (!match) begin
      mRun = 0;
    end else if (mRun == 2) begin
      mZ = 1;
      mRun = 0;
      if (mPhase == 0) begin
        mHits = mHits + 1;
        if (mHits == 2) begin
          mPhase = 1;
          mHits = 0;
        end
      end else begin
        mPhase = 0;
      end
    end else begin
      mRun = mRun + 1;
    end
  endfunction

  task automatic check(bit exp, string tag);
    checks++;
    if (detectOut !== exp) begin
      errors++;
      $display("FAIL %s: detectOut=%0b expected=%0b at %0t", tag, detectOut, exp, $time);
    end
  endtask

  // drive one bit at a falling edge, sample after the next rising edge
  task automatic sendExp(bit b, bit exp, string tag);
    dataIn = b;
    refStep(b);
    @(negedge clk);
    check(exp, tag);
    if (mZ != exp) $display("note: directed expectation differs from reference (%s)", tag);
  endtask

  task automatic sendRef(bit b, string tag);
    dataIn = b;
    refStep(b);
    @(negedge clk);
    check(mZ, tag);
  endtask

  task automatic doReset();
    rst = 1'b1;
    dataIn = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    refReset();
    check(1'b0, "R1 reset");
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    @(negedge clk);
    @(negedge clk);
    doReset();

    // R4: broken runs give nothing
    sendExp(0, 0, "R4"); sendExp(0, 0, "R4"); sendExp(1, 0, "R4");
    sendExp(0, 0, "R4"); sendExp(0, 0, "R4"); sendExp(1, 0, "R4");
    // R2: first hit
    sendExp(0, 0, "R2"); sendExp(0, 0, "R2"); sendExp(0, 1, "R2");
    // R3/R8: continuing zeros do not reuse the run
    sendExp(0, 0, "R8"); sendExp(0, 0, "R3"); sendExp(0, 1, "R3");
    // R5: now in the one phase, zeros ignored
    sendExp(0, 0, "R5"); sendExp(0, 0, "R5"); sendExp(0, 0, "R5");
    sendExp(0, 0, "R5"); sendExp(0, 0, "R5");
    // R6: 111 hit, then more ones ignored
    sendExp(1, 0, "R6"); sendExp(1, 0, "R6"); sendExp(1, 1, "R6");
    sendExp(1, 0, "R6"); sendExp(1, 0, "R6"); sendExp(1, 0, "R6");
    // R7: ones before the second zero hit do not count
    sendExp(0, 0, "R7"); sendExp(0, 0, "R7"); sendExp(0, 1, "R7");
    sendExp(1, 0, "R7"); sendExp(1, 0, "R7");
    sendExp(0, 0, "R7"); sendExp(0, 0, "R7"); sendExp(0, 1, "R7");
    sendExp(1, 0, "R7"); sendExp(1, 0, "R7"); sendExp(1, 1, "R7");

    // R1: reset drops a partial run
    sendExp(0, 0, "R1"); sendExp(0, 0, "R1");
    doReset();
    sendExp(0, 0, "R1"); sendExp(0, 0, "R1"); sendExp(0, 1, "R1");
    doReset();

    // random runs against the reference model
    for (int r = 0; r < 1500; r++) begin
      bit b;
      int len;
      b = 1'($urandom % 2);
      len = 1 + int'($urandom % 6);
      for (int k = 0; k < len; k++) sendRef(b, "R2/R3/R5/R6 random");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule